// File: doc/BRIEF.md
# Idle Mode and Clock-Divider Controller

This block manages power for a small microcontroller. It has two byte-wide registers on a simple write/read port. One holds an idle flag. The other holds a clock-select field. From the oscillator clock it builds a one-cycle clock-enable pulse, at a rate set by a power-of-two divider. It drives that pulse out twice:

- as a peripheral clock enable, which always runs;
- as a CPU clock enable, which is held low while the idle flag is set.

Software sets the idle flag to stop the CPU. The interrupt controller, timers, serial interfaces, converter and watchdog keep running on the peripheral enable. The idle flag is cleared by hardware when any interrupt request arrives whose enable bit is also set. A one-cycle wake pulse reports that event. The idle flag is also cleared by the external reset input, which returns every control register to its default. The divide setting is in force at all times, not only during idle. A new setting is taken up only when the current divider period ends, so a shortened enable period never appears.

Top module: `pwr_idle_ctl`

## Requirements
- R1: After reset the following hold: `idle` is 0, both registers read 0x00, and `per_clk_en` and `cpu_clk_en` are high on every cycle (divide by 1).
- R2: A write with `reg_addr`=0 and `reg_wdata` bit 0 = 1 sets `idle` at the clock edge that takes the write, provided no enabled interrupt is pending. Register 0 then reads 0x01.
- R3: While `idle` is 1, `cpu_clk_en` stays 0 and `per_clk_en` keeps pulsing at the selected rate.
- R4: While `idle` is 1, a cycle with `irq_req & irq_en` nonzero clears `idle` at the next edge. `wake_pulse` is 1 for exactly that one following cycle. A request whose enable bit is 0 leaves `idle` at 1.
- R5: `ext_rst` high at a clock edge clears `idle`, the select field and the divider, just as `rst_n` low does.
- R6: The select field is register 1, bits [2:0]. A value n makes `per_clk_en` pulse once every 2^n cycles: 0 means every cycle and 7 means every 128 cycles.
- R7: The selected divide ratio applies to `per_clk_en` whether or not `idle` is set.
- R8: A new select value takes effect only after the current divider period completes. If select 7 is replaced by 0 just after a pulse, the next pulse still comes 128 cycles after the last one. From then on a pulse comes every cycle.
- R9: Unused bits read 0. Register 1 bits [7:3] and register 0 bits [7:1] return 0 regardless of what was written.
- R10: If a write that sets `idle` lands in the same cycle as an enabled interrupt request, the interrupt wins and `idle` stays 0.
- R11: While `idle` is 0, `cpu_clk_en` equals `per_clk_en` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_rst | input | 1 | External reset pin, active high, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 power control, 1 clock select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_req | input | IRQ_N | Interrupt request lines |
| irq_en | input | IRQ_N | Per-line interrupt enables |
| idle | output | 1 | Idle flag |
| wake_pulse | output | 1 | One-cycle pulse after idle is cleared by an interrupt |
| cpu_clk_en | output | 1 | Gated CPU clock enable |
| per_clk_en | output | 1 | Free-running peripheral clock enable |

## Verification
The bench builds the block with its default parameters: a 3-bit select field, which gives a 7-bit prescaler, and eight interrupt lines. At these values the bench can walk all eight divide ratios, including the 128-cycle maximum. Each ratio is measured by counting enable pulses over a 256-cycle window, and 256 is a multiple of every period. The bench also tests that a change from the longest period to the shortest waits for the current period to end. Because there are eight interrupt lines, it can test that a request with its enable bit clear is ignored while a different line is enabled.

// File: rtl/pwr_idle_pkg.sv
// Shared constants for the idle / clock-divider controller.
// Assumes a byte-wide register port with two addressable registers.
package pwr_idle_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 1;
    localparam logic [ADDR_W-1:0] ADDR_PCTL = 1'b0;  // power control, bit 0 = idle
    localparam logic [ADDR_W-1:0] ADDR_CSEL = 1'b1;  // clock select field
endpackage

// File: rtl/pwr_ctl_regs.sv
// Control registers: idle flag with hardware wake-up, clock-select field,
// and the combinational read mux. Assumes srst_n already folds in ext reset.
module pwr_ctl_regs
    import pwr_idle_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int IRQ_N = 8
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    output logic              idle_o,
    output logic              wake_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic wake_req;
    logic idle_q;
    logic wake_q;
    logic [SEL_W-1:0] sel_q;

    // Any enabled request counts as a wake-up source.
    assign wake_req = |(irq_req & irq_en);

    // Idle flag: interrupt beats a simultaneous idle write.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            idle_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= idle_q & wake_req;
            if (wake_req)
                idle_q <= 1'b0;
            else if (reg_wr && reg_addr == ADDR_PCTL)
                idle_q <= reg_wdata[0];
        end
    end

    // Clock-select field, low bits of register 1.
    always_ff @(posedge clk) begin
        if (!srst_n)
            sel_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CSEL)
            sel_q <= reg_wdata[SEL_W-1:0];
    end

    // Read mux; unused bits return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_PCTL)
            reg_rdata[0] = idle_q;
        else
            reg_rdata[SEL_W-1:0] = sel_q;
    end

    assign idle_o = idle_q;
    assign wake_o = wake_q;
    assign sel_o  = sel_q;
endmodule

// File: rtl/pwr_prescaler.sv
// Power-of-two prescaler producing a one-cycle enable every 2^sel cycles.
// The requested select is sampled only at a period end, so no short period.
module pwr_prescaler #(
    parameter int SEL_W = 3,
    localparam int PS_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic [SEL_W-1:0] sel_req,
    output logic             div_en
);
    logic [SEL_W-1:0] sel_act;
    logic [PS_W-1:0]  cnt;
    logic [PS_W:0]    one_sh;
    logic [PS_W-1:0]  limit;

    // Terminal count for the active ratio: 2^sel_act - 1.
    always_comb begin
        one_sh = (PS_W+1)'(1) << sel_act;
        limit  = one_sh[PS_W-1:0] - PS_W'(1);
    end

    assign div_en = (cnt == limit);

    // Count, and adopt the new ratio at wrap.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            cnt     <= '0;
            sel_act <= '0;
        end else if (div_en) begin
            cnt     <= '0;
            sel_act <= sel_req;
        end else begin
            cnt <= cnt + PS_W'(1);
        end
    end
endmodule

// File: rtl/pwr_clk_gate.sv
// Clock-enable gating: peripheral enable passes through, CPU enable is
// suppressed while idle. Purely combinational.
module pwr_clk_gate (
    input  logic div_en,
    input  logic idle,
    output logic cpu_en,
    output logic per_en
);
    // Gate the CPU enable only.
    always_comb begin
        per_en = div_en;
        cpu_en = div_en & ~idle;
    end
endmodule

// File: rtl/pwr_idle_ctl.sv
// Top of the idle / clock-divider controller. Folds the external reset pin
// into the synchronous reset and wires registers, prescaler and gating.
module pwr_idle_ctl
    import pwr_idle_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int IRQ_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_en,
    output logic              idle,
    output logic              wake_pulse,
    output logic              cpu_clk_en,
    output logic              per_clk_en
);
    logic             srst_n;
    logic [SEL_W-1:0] sel;
    logic             div_en;

    assign srst_n = rst_n & ~ext_rst;

    pwr_ctl_regs #(.SEL_W(SEL_W), .IRQ_N(IRQ_N)) u_regs (
        .clk(clk), .srst_n(srst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_en(irq_en), .idle_o(idle), .wake_o(wake_pulse), .sel_o(sel)
    );

    pwr_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk(clk), .srst_n(srst_n), .sel_req(sel), .div_en(div_en)
    );

    pwr_clk_gate u_gate (
        .div_en(div_en), .idle(idle), .cpu_en(cpu_clk_en), .per_en(per_clk_en)
    );
endmodule

// File: rtl/pwr_idle_ctl_chk.sv
// Property checker for pwr_idle_ctl, bound to every instance of the top.
module pwr_idle_ctl_chk #(
    parameter int IRQ_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_rst,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [IRQ_N-1:0] irq_req,
    input logic [IRQ_N-1:0] irq_en,
    input logic             idle,
    input logic             wake_pulse,
    input logic             cpu_clk_en,
    input logic             per_clk_en
);
    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        (reg_wr && reg_addr == 1'b0 && reg_wdata[0] && !(|(irq_req & irq_en))) |=> idle);

    assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        idle |-> !cpu_clk_en);

    assert_wake_clears_R4: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        (idle && |(irq_req & irq_en)) |=> (!idle && wake_pulse));

    assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        wake_pulse |=> !wake_pulse);

    assert_ext_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (!idle && !wake_pulse));

    assert_irq_priority_R10: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        (reg_wr && reg_addr == 1'b0 && reg_wdata[0] && |(irq_req & irq_en)) |=> !idle);

    assert_cpu_follows_R11: assert property (@(posedge clk) disable iff (!rst_n || ext_rst)
        !idle |-> (cpu_clk_en == per_clk_en));
endmodule

bind pwr_idle_ctl pwr_idle_ctl_chk #(.IRQ_N(IRQ_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_req(irq_req),
    .irq_en(irq_en), .idle(idle), .wake_pulse(wake_pulse),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
);

// File: tb/sim_pwr_idle_ctl.sv
`timescale 1ns/1ps
module sim_pwr_idle_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_req = 8'h00;
    logic [7:0] irq_en = 8'h00;
    logic       idle, wake_pulse, cpu_clk_en, per_clk_en;

    int n_run = 0;
    int n_fail = 0;

    // {select, expected pulses in 256 cycles}
    localparam logic [11:0] VEC [0:7] = '{
        {3'd3, 9'd32}, {3'd0, 9'd256}, {3'd7, 9'd2}, {3'd1, 9'd128},
        {3'd5, 9'd8},  {3'd2, 9'd64},  {3'd6, 9'd4}, {3'd4, 9'd16}
    };

    always #10 clk = ~clk;

    pwr_idle_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_en(irq_en), .idle(idle), .wake_pulse(wake_pulse),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count256(output int per, output int cpu);
        per = 0; cpu = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (per_clk_en) per++;
            if (cpu_clk_en) cpu++;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int per, cpu, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle", idle, 0);
        rd(1'b0, d); check("R1 reg0", d, 0);
        rd(1'b1, d); check("R1 reg1", d, 0);
        check("R1 per_clk_en", per_clk_en, 1);
        check("R1 cpu_clk_en", cpu_clk_en, 1);

        // R6 / R11 table of divide ratios
        for (int v = 0; v < 8; v++) begin
            wr(1'b1, {5'd0, VEC[v][11:9]});
            repeat (300) @(negedge clk);
            count256(per, cpu);
            check("R6 pulses", per, int'(VEC[v][8:0]));
            check("R11 cpu equals per", cpu, int'(VEC[v][8:0]));
        end

        // R9 unused bits
        wr(1'b1, 8'hFA);
        rd(1'b1, d); check("R9 reg1 mask", d, 8'h02);
        wr(1'b0, 8'hFE);
        rd(1'b0, d); check("R9 reg0 mask", d, 8'h00);
        check("R9 idle untouched", idle, 0);

        // R2 enter idle
        wr(1'b0, 8'h01);
        check("R2 idle", idle, 1);
        rd(1'b0, d); check("R2 reg0", d, 8'h01);

        // R3 / R7 divided peripheral enable in idle (select 2 active)
        repeat (10) @(negedge clk);
        count256(per, cpu);
        check("R7 per in idle", per, 64);
        check("R3 cpu in idle", cpu, 0);

        // R4 disabled request ignored, enabled one wakes
        irq_req = 8'h10; irq_en = 8'h01;
        repeat (4) @(negedge clk);
        check("R4 disabled irq", idle, 1);
        irq_en = 8'h11;
        @(negedge clk);
        irq_req = 8'h00; irq_en = 8'h00;
        check("R4 woke", idle, 0);
        check("R4 wake_pulse", wake_pulse, 1);
        @(negedge clk);
        check("R4 pulse width", wake_pulse, 0);

        // R10 interrupt beats idle write
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01;
        irq_req = 8'h02; irq_en = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0; irq_req = 8'h00; irq_en = 8'h00;
        check("R10 idle", idle, 0);
        check("R10 no wake_pulse", wake_pulse, 0);

        // R5 external reset clears everything
        wr(1'b1, 8'h05);
        wr(1'b0, 8'h01);
        check("R5 pre idle", idle, 1);
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        check("R5 idle", idle, 0);
        rd(1'b1, d); check("R5 sel", d, 0);
        check("R5 per_clk_en", per_clk_en, 1);
        @(negedge clk);
        check("R5 per every cycle", per_clk_en, 1);

        // R8 new ratio waits for period end
        wr(1'b1, 8'h07);
        repeat (300) @(negedge clk);
        n = 0;
        while (!per_clk_en && n < 200) begin @(negedge clk); n++; end
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h00;
        n = 0;
        do begin
            @(negedge clk);
            reg_wr = 1'b0;
            n++;
        end while (!per_clk_en && n < 300);
        check("R8 old period kept", n, 128);
        @(negedge clk);
        check("R8 new ratio", per_clk_en, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule